// File: doc/BRIEF.md
# Jam-Loaded Reference and Feedback Dividers

This block divides two sampled input waveforms, a reference and a VCO feedback signal, by programmable ratios to produce the two comparison pulses that a phase/frequency detector consumes. Both inputs are sampled levels in the single system clock domain, so each input level change acts as a clock enable. The reference divider has a 15-bit ratio and the feedback divider a 16-bit ratio. Each divider counts rising input edges downward and emits one pulse per division. A third path derives a buffered reference output through a coded power-of-two prescaler.

A single-cycle jam strobe, raised whenever software writes a new feedback ratio, reloads both counters together so that the two dividers restart in phase. Separate enable inputs gate copies of the pulses onto pins. The internal pulses keep running for the detector whatever those enables say.

Top module: `jam_divider_pair`

## Requirements
- R1: Each divider counts only rising input edges and ends one division after exactly its effective ratio of rising edges since the last reload. It then starts a new pulse on that edge's clock and reloads itself.
- R2: A reference ratio of 0, 2, 3 or 4 behaves as 5. A feedback ratio below 40 behaves as 40. All other ratio values are used as given.
- R3: The jam strobe loads both counters with their effective ratios and drops any pulse in progress. A rising edge sampled in the same clock as the jam is not counted.
- R4: The reference pulse stays high from its starting rising edge until the fifth falling reference edge after it, which is 4.5 reference periods. The feedback pulse stays high until the next falling VCO edge.
- R5: With a reference ratio of exactly 1, `fr_o` follows the reference level, delayed by one clock.
- R6: `fr_pin_o` and `fv_pin_o` equal the internal pulses when their enable is 1 and are held low when it is 0. The internal pulses are unaffected by the enables.
- R7: The 3-bit `refout_sel_i` selects the reference output as follows: 000 static low, 001 reference level, 010 divide by 2, 011 divide by 4, 100 and 110 divide by 8, 101 and 111 divide by 16. The divided outputs are bits of a free-running counter of rising reference edges.
- R8: While `rst_ni` is low, all outputs are low regardless of input activity. After reset, the first rising edge on an input ends a division for that divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Sampled reference waveform level |
| vco_i | input | 1 | Sampled VCO feedback waveform level |
| r_ratio_i | input | 15 | Reference divide ratio |
| n_ratio_i | input | 16 | Feedback divide ratio |
| jam_i | input | 1 | Reload both counters in phase |
| fr_pin_en_i | input | 1 | Enable for the reference pulse pin |
| fv_pin_en_i | input | 1 | Enable for the feedback pulse pin |
| refout_sel_i | input | 3 | Reference output prescaler code |
| fr_o | output | 1 | Internal reference pulse for the detector |
| fv_o | output | 1 | Internal feedback pulse for the detector |
| fr_pin_o | output | 1 | Gated reference pulse for the pin |
| fv_pin_o | output | 1 | Gated feedback pulse for the pin |
| refout_o | output | 1 | Prescaled reference output |

## Verification
A jam strobe and a rising reference edge can land in the same clock. The bench provokes this by raising `jam_i` at the very clock where the reference level first reads high. It then judges the result from the pulse count: no reference pulse may appear after four further edges, and exactly one must appear after the fifth. A second collision, a jam arriving while a reference pulse is high, must clear `fr_o` on the next clock.

// File: rtl/jdp_pkg.sv
`timescale 1ns/1ps
package jdp_pkg;
  typedef enum logic [2:0] {
    REF_OFF       = 3'b000,
    REF_DIV1      = 3'b001,
    REF_DIV2      = 3'b010,
    REF_DIV4      = 3'b011,
    REF_DIV8      = 3'b100,
    REF_DIV16     = 3'b101,
    REF_DIV8_ALT  = 3'b110,
    REF_DIV16_ALT = 3'b111
  } refout_sel_e;

  localparam int unsigned R_MIN_RATIO   = 5;
  localparam int unsigned N_MIN_RATIO   = 40;
  localparam int unsigned R_PULSE_FALLS = 5;
  localparam int unsigned V_PULSE_FALLS = 1;
  localparam int unsigned PRESCALE_BITS = 4;
endpackage

// File: rtl/jdp_edge_sense.sv
`timescale 1ns/1ps
module jdp_edge_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= sig_i;
  end

  assign lvl_o  = lvl_q;
  assign rise_o = sig_i & ~lvl_q;
  assign fall_o = ~sig_i & lvl_q;
endmodule

// File: rtl/jdp_ratio_divider.sv
`timescale 1ns/1ps
module jdp_ratio_divider #(
  parameter int unsigned WIDTH       = 15,
  parameter int unsigned MIN_RATIO   = 5,
  parameter int unsigned PASS_ONE    = 1,
  parameter int unsigned PULSE_FALLS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] ratio_i,
  input  logic             jam_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             pulse_o
);
  localparam int unsigned FW = $clog2(PULSE_FALLS + 1);

  logic [WIDTH-1:0] ratio_eff;
  logic [WIDTH-1:0] cnt_q;
  logic [FW-1:0]    falls_q;
  logic             pulse_q;

  always_comb begin
    ratio_eff = ratio_i;
    if (PASS_ONE != 0 && ratio_i == WIDTH'(1)) ratio_eff = ratio_i;
    else if (ratio_i < WIDTH'(MIN_RATIO))      ratio_eff = WIDTH'(MIN_RATIO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      falls_q <= '0;
    end else if (jam_i) begin
      // reload wins over a coincident edge
      cnt_q   <= ratio_eff;
      pulse_q <= 1'b0;
      falls_q <= '0;
    end else begin
      if (rise_i) begin
        if (cnt_q <= WIDTH'(1)) begin
          cnt_q   <= ratio_eff;
          pulse_q <= 1'b1;
          falls_q <= '0;
        end else begin
          cnt_q <= cnt_q - WIDTH'(1);
        end
      end
      if (fall_i && pulse_q) begin
        if (falls_q == FW'(PULSE_FALLS - 1)) begin
          pulse_q <= 1'b0;
          falls_q <= '0;
        end else begin
          falls_q <= falls_q + FW'(1);
        end
      end
    end
  end

  assign pulse_o = pulse_q;

  p_jam_clears_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_i |=> !pulse_q);
  p_count_only_on_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i && !jam_i |=> $stable(cnt_q));
  p_pulse_starts_on_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $rose(pulse_q) |-> $past(rise_i) && !$past(jam_i));
  p_pulse_ends_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $fell(pulse_q) |-> $past(fall_i) || $past(jam_i));
endmodule

// File: rtl/jdp_ref_prescaler.sv
`timescale 1ns/1ps
module jdp_ref_prescaler
  import jdp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_i,
  input  logic        lvl_i,
  input  refout_sel_e sel_i,
  output logic        refout_o
);
  logic [PRESCALE_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (rise_i) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      REF_OFF:                   refout_o = 1'b0;
      REF_DIV1:                  refout_o = lvl_i;
      REF_DIV2:                  refout_o = cnt_q[0];
      REF_DIV4:                  refout_o = cnt_q[1];
      REF_DIV8, REF_DIV8_ALT:    refout_o = cnt_q[2];
      REF_DIV16, REF_DIV16_ALT:  refout_o = cnt_q[3];
      default:                   refout_o = 1'b0;
    endcase
  end

  p_div2_toggles_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && sel_i == REF_DIV2 && $past(sel_i) == REF_DIV2 && $past(rise_i)
    |-> refout_o != $past(refout_o));
endmodule

// File: rtl/jam_divider_pair.sv
`timescale 1ns/1ps
module jam_divider_pair
  import jdp_pkg::*;
#(
  parameter int unsigned R_WIDTH = 15,
  parameter int unsigned N_WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_i,
  input  logic               vco_i,
  input  logic [R_WIDTH-1:0] r_ratio_i,
  input  logic [N_WIDTH-1:0] n_ratio_i,
  input  logic               jam_i,
  input  logic               fr_pin_en_i,
  input  logic               fv_pin_en_i,
  input  logic [2:0]         refout_sel_i,
  output logic               fr_o,
  output logic               fv_o,
  output logic               fr_pin_o,
  output logic               fv_pin_o,
  output logic               refout_o
);
  logic ref_lvl, ref_rise, ref_fall;
  logic vco_lvl, vco_rise, vco_fall;
  logic r_pulse, n_pulse;

  jdp_edge_sense u_ref_edge (
    .clk_i, .rst_ni, .sig_i(ref_i),
    .lvl_o(ref_lvl), .rise_o(ref_rise), .fall_o(ref_fall)
  );

  jdp_edge_sense u_vco_edge (
    .clk_i, .rst_ni, .sig_i(vco_i),
    .lvl_o(vco_lvl), .rise_o(vco_rise), .fall_o(vco_fall)
  );

  jdp_ratio_divider #(
    .WIDTH(R_WIDTH), .MIN_RATIO(R_MIN_RATIO), .PASS_ONE(1), .PULSE_FALLS(R_PULSE_FALLS)
  ) u_r_div (
    .clk_i, .rst_ni, .ratio_i(r_ratio_i), .jam_i,
    .rise_i(ref_rise), .fall_i(ref_fall), .pulse_o(r_pulse)
  );

  jdp_ratio_divider #(
    .WIDTH(N_WIDTH), .MIN_RATIO(N_MIN_RATIO), .PASS_ONE(0), .PULSE_FALLS(V_PULSE_FALLS)
  ) u_n_div (
    .clk_i, .rst_ni, .ratio_i(n_ratio_i), .jam_i,
    .rise_i(vco_rise), .fall_i(vco_fall), .pulse_o(n_pulse)
  );

  jdp_ref_prescaler u_refout (
    .clk_i, .rst_ni, .rise_i(ref_rise), .lvl_i(ref_lvl),
    .sel_i(refout_sel_e'(refout_sel_i)), .refout_o
  );

  // ratio 1 bypasses the counter
  assign fr_o     = (r_ratio_i == R_WIDTH'(1)) ? ref_lvl : r_pulse;
  assign fv_o     = n_pulse;
  assign fr_pin_o = fr_o & fr_pin_en_i;
  assign fv_pin_o = fv_o & fv_pin_en_i;

  p_fv_rises_with_vco_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $rose(fv_o) |-> vco_lvl);
endmodule

// File: tb/jam_divider_pair_tb.sv
`timescale 1ns/1ps
module jam_divider_pair_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_i = 1'b0, vco_i = 1'b0, jam_i = 1'b0;
  logic [14:0] r_ratio = 15'd5;
  logic [15:0] n_ratio = 16'd40;
  logic        fr_en = 1'b1, fv_en = 1'b1;
  logic [2:0]  sel = 3'b001;
  logic        fr_o, fv_o, fr_pin_o, fv_pin_o, refout_o;

  int checks = 0, failures = 0;
  int fr_n = 0, fv_n = 0, frp_n = 0, fvp_n = 0, ref_n = 0;
  int fr_run = 0, fr_w = 0, fv_run = 0, fv_w = 0;
  logic p_fr = 0, p_fv = 0, p_frp = 0, p_fvp = 0, p_ref = 0;

  always #2.5 clk = ~clk;

  jam_divider_pair u_dut (
    .clk_i(clk), .rst_ni, .ref_i, .vco_i, .r_ratio_i(r_ratio), .n_ratio_i(n_ratio),
    .jam_i, .fr_pin_en_i(fr_en), .fv_pin_en_i(fv_en), .refout_sel_i(sel),
    .fr_o, .fv_o, .fr_pin_o, .fv_pin_o, .refout_o
  );

  // r, n, fr_en, fv_en, ref cycles, expected fr pulses, expected fv pulses
  localparam int NVEC = 6;
  localparam int VEC [NVEC][7] = '{
    '{5,  40, 1, 1, 20, 4, 1},
    '{7,  50, 0, 1, 30, 4, 1},
    '{1,  40, 1, 0, 10, 10, 0},
    '{3,  10, 0, 0, 41, 8, 2},
    '{0,  45, 1, 1, 25, 5, 1},
    '{6,  41, 1, 0, 42, 7, 2}
  };

  always @(posedge clk) begin
    #1;
    if (fr_o && !p_fr) fr_n++;
    if (fv_o && !p_fv) fv_n++;
    if (fr_pin_o && !p_frp) frp_n++;
    if (fv_pin_o && !p_fvp) fvp_n++;
    if (refout_o && !p_ref) ref_n++;
    if (fr_o) fr_run++; else begin if (p_fr) fr_w = fr_run; fr_run = 0; end
    if (fv_o) fv_run++; else begin if (p_fv) fv_w = fv_run; fv_run = 0; end
    p_fr = fr_o; p_fv = fv_o; p_frp = fr_pin_o; p_fvp = fv_pin_o; p_ref = refout_o;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one reference period = 4 clocks, two VCO periods inside it
  task automatic run_ref(int n);
    for (int k = 0; k < n; k++) begin
      ref_i = 1; vco_i = 1; @(negedge clk);
      vco_i = 0;            @(negedge clk);
      ref_i = 0; vco_i = 1; @(negedge clk);
      vco_i = 0;            @(negedge clk);
    end
  endtask

  task automatic jam_now();
    jam_i = 1; @(negedge clk);
    jam_i = 0;
  endtask

  function automatic int refout_exp(int s);
    case (s)
      0: return 0;
      1: return 16;
      2: return 8;
      3: return 4;
      4, 6: return 2;
      default: return 1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int b_fr, b_fv, b_frp, b_fvp, b_ref;
    // R8: outputs low during reset despite input activity
    @(negedge clk); ref_i = 1; vco_i = 1;
    @(negedge clk); ref_i = 0; vco_i = 0;
    @(negedge clk); ref_i = 1; vco_i = 1;
    @(negedge clk);
    check("R8 fr_o in reset", fr_o, 0);
    check("R8 fv_o in reset", fv_o, 0);
    check("R8 refout_o in reset", refout_o, 0);
    check("R8 pins in reset", fr_pin_o | fv_pin_o, 0);
    ref_i = 0; vco_i = 0;
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    check("R8 fr_o after reset", fr_o, 0);

    // table-driven division: R1 R2 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      r_ratio = 15'(VEC[i][0]); n_ratio = 16'(VEC[i][1]);
      fr_en = VEC[i][2][0]; fv_en = VEC[i][3][0];
      @(negedge clk);
      jam_now();
      @(negedge clk);
      b_fr = fr_n; b_fv = fv_n; b_frp = frp_n; b_fvp = fvp_n;
      run_ref(VEC[i][4]);
      check($sformatf("R1/R2/R5 fr pulses vec%0d", i), fr_n - b_fr, VEC[i][5]);
      check($sformatf("R1/R2 fv pulses vec%0d", i), fv_n - b_fv, VEC[i][6]);
      check($sformatf("R6 fr pin pulses vec%0d", i), frp_n - b_frp, VEC[i][2] != 0 ? VEC[i][5] : 0);
      check($sformatf("R6 fv pin pulses vec%0d", i), fvp_n - b_fvp, VEC[i][3] != 0 ? VEC[i][6] : 0);
      if (i == 0) begin
        check("R4 fr pulse width clocks", fr_w, 18);
        check("R4 fv pulse width clocks", fv_w, 1);
      end
    end

    // R5: pass-through latency of one clock
    r_ratio = 15'd1; @(negedge clk);
    ref_i = 1; @(negedge clk);
    check("R5 fr follows ref high", fr_o, 1);
    ref_i = 0; @(negedge clk);
    check("R5 fr follows ref low", fr_o, 0);

    // R3: jam and rising edge in the same clock, edge not counted
    r_ratio = 15'd5; fr_en = 1; @(negedge clk);
    b_fr = fr_n;
    ref_i = 1; vco_i = 1; jam_i = 1; @(negedge clk);
    jam_i = 0; vco_i = 0; @(negedge clk);
    ref_i = 0; vco_i = 1; @(negedge clk);
    vco_i = 0; @(negedge clk);
    run_ref(4);
    check("R3 coincident edge ignored", fr_n - b_fr, 0);
    run_ref(1);
    check("R3 pulse on fifth edge after jam", fr_n - b_fr, 1);
    check("R3 pulse high before jam", fr_o, 1);
    jam_now();
    check("R3 jam clears pulse", fr_o, 0);

    // R7: prescaler codes over 16 reference periods
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      @(negedge clk); @(negedge clk);
      b_ref = ref_n;
      run_ref(16);
      check($sformatf("R7 refout rises sel=%0d", s), ref_n - b_ref, refout_exp(s));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule